// File: doc/BRIEF.md
# Protection Configuration Write Guard

This block sits between the software write path of a physical memory protection unit and the storage for its entries. Each write carries three things: a base entry index, a choice between the address register and the packed configuration bytes, and the data word. The guard compares the write with the lock state and matching mode of every entry, and with the two security control bits. The first control bit is a lockdown bit that changes what locked rules mean. The second is a bypass bit that lifts rule locking. From these the guard decides which storage write enables to raise and what value to store.

A configuration write carries `CFG_BYTES` bytes. Byte j of the data belongs to entry `req_index + j`. The guard checks each byte on its own, so one refused byte never blocks its neighbours. An address write targets only entry `req_index`. A refused write has no effect other than the `rejected` flag and raises no exception.

The controller has two states. `GS_IDLE` means no result is being presented. `GS_ISSUE` means the registered result of the previous cycle's request is on the outputs. The transitions are:
- `GS_IDLE` to `GS_ISSUE` when `req_valid` is high.
- `GS_ISSUE` to `GS_ISSUE` when another request arrives back to back.
- `GS_ISSUE` to `GS_IDLE` when no request arrives.

Every request therefore produces its result exactly one cycle after it is presented.

Top module: `prot_write_guard`

## Requirements
- R1: A configuration byte aimed at an entry whose lock input is 1 is not committed while the bypass bit is 0. The configuration byte layout is: bit0 read, bit1 write, bit2 execute, bits 4:3 matching mode, bit7 lock.
- R2: An address write to an entry whose lock input is 1 is not committed while the bypass bit is 0.
- R3: With the bypass bit at 1, writes to locked entries commit, and the lockdown shape restrictions of R4 and R5 are lifted.
- R4: With lockdown 1 and bypass 0, a configuration byte whose new value has lock=1 and execute=1 is refused when the read/write pair is 00 or 10, that is, a machine-only executable rule.
- R5: With lockdown 1 and bypass 0, a configuration byte whose new value has lock=1, read=0 and write=1 is refused whatever its execute bit, since that value is a locked shared code region.
- R6: With lockdown 1, a new value with lock, read, write and execute all 1 (0x87 with mode 00) is accepted.
- R7: With lockdown 0, a committed byte whose read=0 and write=1 is stored with bits 2:0 cleared, while bits 7:3 are kept. With lockdown 1 the same byte is stored unchanged.
- R8: With bypass 0, the address register of entry i-1 is refused when entry i is locked and its matching mode input is top-of-range (mode code 01). Any other mode of entry i leaves entry i-1 writable.
- R9: Configuration bytes are judged independently. `rejected` is 1 exactly when at least one in-range byte, or the address write, was refused.
- R10: Results appear, with `out_valid`, on the cycle after `req_valid`. While `out_valid` is 0, all write enables and `rejected` are 0. Configuration bytes whose entry index is at or beyond `N_ENTRIES` are dropped silently and do not set `rejected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present this cycle |
| req_is_cfg | input | 1 | 1: configuration bytes, 0: address register |
| req_index | input | IDX_W | Target (base) entry index |
| req_data | input | DATA_W | Write data; byte j goes to entry req_index+j for configuration writes |
| entry_lock | input | N_ENTRIES | Current lock bit of each entry |
| entry_mode | input | 2*N_ENTRIES | Current matching mode of each entry, two bits per entry, 01 = top-of-range |
| mml | input | 1 | Machine lockdown control bit |
| rlb | input | 1 | Rule lock bypass control bit |
| out_valid | output | 1 | Result of the previous cycle's request is presented |
| cfg_we | output | N_ENTRIES | Per-entry configuration byte write enable |
| addr_we | output | N_ENTRIES | Per-entry address register write enable |
| wr_data | output | DATA_W | Value to store (adjusted bytes or address) |
| rejected | output | 1 | At least one part of the request was refused |

## Verification
The bench aims at the boundary between the shapes that lockdown forbids and the one it allows. These are 0x85, 0x84, 0x82, 0x86 and 0x87. A guard that tested only the execute bit would wrongly refuse the all-ones shared data value. A guard that missed the read=0/write=1 case would let a locked shared code region through. Mixed configuration words put a locked entry next to unlocked ones. A guard that refused the whole word would drop the neighbours' enables. The neighbour rule for top-of-range matching is checked against a non-TOR mode and against the last entry. Mishandling it would either freeze an address that should stay writable or leave a protected boundary writable. Base indices near the top make bytes fall off the end of the entry array. Those must vanish silently rather than wrap onto entry 0 or raise `rejected`.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

    localparam int CB_READ   = 0;
    localparam int CB_WRITE  = 1;
    localparam int CB_EXEC   = 2;
    localparam int CB_MODE_L = 3;
    localparam int CB_LOCK   = 7;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'b00,
        MATCH_TOR   = 2'b01,
        MATCH_NA4   = 2'b10,
        MATCH_NAPOT = 2'b11
    } match_mode_e;

    typedef enum logic {
        GS_IDLE  = 1'b0,
        GS_ISSUE = 1'b1
    } guard_state_e;

    // read=0, write=1: reserved without lockdown, shared region with it
    function automatic logic is_wo_shape(input logic [7:0] b);
        return !b[CB_READ] && b[CB_WRITE];
    endfunction

    // New value that lockdown forbids unless the bypass is set
    function automatic logic lockdown_forbidden(input logic [7:0] b);
        logic rwx_all;
        rwx_all = b[CB_READ] && b[CB_WRITE] && b[CB_EXEC];
        return b[CB_LOCK] && (is_wo_shape(b) || (b[CB_EXEC] && !rwx_all));
    endfunction

endpackage

// File: rtl/cfg_byte_check.sv
module cfg_byte_check
    import prot_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_range,
    input  logic       target_locked,
    input  logic       mml,
    input  logic       rlb,
    input  logic [7:0] new_byte,
    output logic       commit,
    output logic       refused,
    output logic [7:0] store_byte
);

    logic lock_block;
    logic shape_block;

    always_comb begin
        lock_block  = target_locked && !rlb;
        shape_block = mml && !rlb && lockdown_forbidden(new_byte);
        refused     = in_range && (lock_block || shape_block);
        commit      = in_range && !lock_block && !shape_block;
        if (!mml && is_wo_shape(new_byte)) begin
            store_byte = {new_byte[7:3], 3'b000};
        end else begin
            store_byte = new_byte;
        end
    end

    // R5: a committed byte under lockdown without bypass is never a locked shared code region
    p_no_locked_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mml && !rlb) |->
        !(store_byte[CB_LOCK] && !store_byte[CB_READ] && store_byte[CB_WRITE]));

    // R7: without lockdown the reserved read=0/write=1 shape never reaches storage
    p_no_reserved_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !mml) |-> !(!store_byte[CB_READ] && store_byte[CB_WRITE]));

endmodule

// File: rtl/addr_check.sv
module addr_check
    import prot_guard_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [IDX_W-1:0]       index,
    input  logic [N_ENTRIES-1:0]   entry_lock,
    input  logic [2*N_ENTRIES-1:0] entry_mode,
    input  logic                   rlb,
    output logic [N_ENTRIES-1:0]   addr_we,
    output logic                   refused
);

    logic [N_ENTRIES-1:0] hit;
    logic [N_ENTRIES-1:0] guarded;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        assign hit[e] = (index == IDX_W'(e));
        if (e + 1 < N_ENTRIES) begin : g_nb
            assign guarded[e] = entry_lock[e] ||
                (entry_lock[e+1] && (entry_mode[2*(e+1) +: 2] == MATCH_TOR));
        end else begin : g_last
            assign guarded[e] = entry_lock[e];
        end
    end

    always_comb begin
        addr_we = '0;
        refused = 1'b0;
        for (int e = 0; e < N_ENTRIES; e++) begin
            if (hit[e]) begin
                if (guarded[e] && !rlb) begin
                    refused = 1'b1;
                end else begin
                    addr_we[e] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/prot_write_guard.sv
module prot_write_guard
    import prot_guard_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int CFG_BYTES = 4,
    parameter int IDX_W     = $clog2(N_ENTRIES),
    parameter int DATA_W    = CFG_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_is_cfg,
    input  logic [IDX_W-1:0]       req_index,
    input  logic [DATA_W-1:0]      req_data,
    input  logic [N_ENTRIES-1:0]   entry_lock,
    input  logic [2*N_ENTRIES-1:0] entry_mode,
    input  logic                   mml,
    input  logic                   rlb,
    output logic                   out_valid,
    output logic [N_ENTRIES-1:0]   cfg_we,
    output logic [N_ENTRIES-1:0]   addr_we,
    output logic [DATA_W-1:0]      wr_data,
    output logic                   rejected
);

    localparam int SUM_W = $clog2(N_ENTRIES + CFG_BYTES) + 1;

    guard_state_e state, state_n;

    logic [CFG_BYTES-1:0] b_commit;
    logic [CFG_BYTES-1:0] b_refused;
    logic [SUM_W-1:0]     b_tgt [CFG_BYTES];
    logic [DATA_W-1:0]    cfg_store;

    logic [N_ENTRIES-1:0] a_we;
    logic                 a_refused;

    logic [N_ENTRIES-1:0] cfg_we_n;
    logic [N_ENTRIES-1:0] q_cfg_we, q_addr_we;
    logic [DATA_W-1:0]    q_data;
    logic                 q_rej;

    // Per-byte configuration checks
    for (genvar j = 0; j < CFG_BYTES; j++) begin : g_byte
        logic             in_rng;
        logic [IDX_W-1:0] safe_idx;
        assign b_tgt[j]  = SUM_W'(req_index) + SUM_W'(j);
        assign in_rng    = (b_tgt[j] < SUM_W'(N_ENTRIES));
        assign safe_idx  = in_rng ? b_tgt[j][IDX_W-1:0] : '0;
        cfg_byte_check u_chk (
            .clk          (clk),
            .rst_n        (rst_n),
            .in_range     (in_rng),
            .target_locked(entry_lock[safe_idx]),
            .mml          (mml),
            .rlb          (rlb),
            .new_byte     (req_data[8*j +: 8]),
            .commit       (b_commit[j]),
            .refused      (b_refused[j]),
            .store_byte   (cfg_store[8*j +: 8])
        );
    end

    addr_check #(
        .N_ENTRIES(N_ENTRIES),
        .IDX_W    (IDX_W)
    ) u_addr (
        .index     (req_index),
        .entry_lock(entry_lock),
        .entry_mode(entry_mode),
        .rlb       (rlb),
        .addr_we   (a_we),
        .refused   (a_refused)
    );

    // Scatter byte commits onto entries
    always_comb begin
        cfg_we_n = '0;
        for (int e = 0; e < N_ENTRIES; e++) begin
            for (int j = 0; j < CFG_BYTES; j++) begin
                if (b_commit[j] && (b_tgt[j] == SUM_W'(e))) begin
                    cfg_we_n[e] = 1'b1;
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GS_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        unique case (state)
            GS_IDLE:  state_n = req_valid ? GS_ISSUE : GS_IDLE;
            GS_ISSUE: state_n = req_valid ? GS_ISSUE : GS_IDLE;
            default:  state_n = GS_IDLE;
        endcase
    end

    // Decision capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_cfg_we  <= '0;
            q_addr_we <= '0;
            q_data    <= '0;
            q_rej     <= 1'b0;
        end else if (req_valid) begin
            if (req_is_cfg) begin
                q_cfg_we  <= cfg_we_n;
                q_addr_we <= '0;
                q_data    <= cfg_store;
                q_rej     <= |b_refused;
            end else begin
                q_cfg_we  <= '0;
                q_addr_we <= a_we;
                q_data    <= req_data;
                q_rej     <= a_refused;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            GS_ISSUE: begin
                out_valid = 1'b1;
                cfg_we    = q_cfg_we;
                addr_we   = q_addr_we;
                wr_data   = q_data;
                rejected  = q_rej;
            end
            default: begin
                out_valid = 1'b0;
                cfg_we    = '0;
                addr_we   = '0;
                wr_data   = '0;
                rejected  = 1'b0;
            end
        endcase
    end

    // R10: a result only follows a request
    p_result_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid));

    // R10: nothing is written while idle
    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (cfg_we == '0 && addr_we == '0 && !rejected));

    // R2: an address write touches at most one entry and never with config enables
    p_addr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(addr_we) && !((|addr_we) && (|cfg_we)));

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_prop
        // R1: configuration of a locked entry only changes with the bypass
        p_cfg_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && cfg_we[e]) |-> ($past(rlb) || !$past(entry_lock[e])));
        // R2: address of a locked entry only changes with the bypass
        p_addr_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && addr_we[e]) |-> ($past(rlb) || !$past(entry_lock[e])));
        if (e + 1 < N_ENTRIES) begin : g_tor
            // R8: lower bound of a locked top-of-range entry stays frozen
            p_tor_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && addr_we[e] && !$past(rlb)) |->
                !($past(entry_lock[e+1]) && ($past(entry_mode[2*(e+1) +: 2]) == MATCH_TOR)));
        end
    end

endmodule

// File: tb/sim_prot_write_guard.sv
module sim_prot_write_guard;

    localparam int N  = 8;
    localparam int CB = 4;
    localparam int IW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_is_cfg;
    logic [IW-1:0] req_index;
    logic [DW-1:0] req_data;
    logic [N-1:0]  entry_lock;
    logic [2*N-1:0] entry_mode;
    logic          mml, rlb;
    logic          out_valid, rejected;
    logic [N-1:0]  cfg_we, addr_we;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic          e_valid, e_rej;
    logic [N-1:0]  e_cfg_we, e_addr_we;
    logic [DW-1:0] e_data;

    always #5 clk = ~clk;

    prot_write_guard #(.N_ENTRIES(N), .CFG_BYTES(CB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_cfg(req_is_cfg),
        .req_index(req_index), .req_data(req_data), .entry_lock(entry_lock),
        .entry_mode(entry_mode), .mml(mml), .rlb(rlb), .out_valid(out_valid),
        .cfg_we(cfg_we), .addr_we(addr_we), .wr_data(wr_data), .rejected(rejected)
    );

    // Behavioural model of one request
    task automatic model();
        e_valid = req_valid; e_cfg_we = '0; e_addr_we = '0; e_data = '0; e_rej = 0;
        if (!req_valid) return;
        if (req_is_cfg) begin
            for (int j = 0; j < CB; j++) begin
                int e = int'(req_index) + j;
                logic [7:0] b = req_data[8*j +: 8];
                bit r = b[0], w = b[1], x = b[2], l = b[7];
                bit refuse;
                if (e >= N) continue;
                refuse = (entry_lock[e] && !rlb) ||
                         (mml && !rlb && l && ((!r && w) || (x && !w)));
                if (refuse) e_rej = 1;
                else begin
                    e_cfg_we[e] = 1;
                    e_data[8*j +: 8] = (!mml && !r && w) ? (b & 8'hF8) : b;
                end
            end
        end else begin
            int e = int'(req_index);
            bit refuse = !rlb && (entry_lock[e] ||
                (e < N-1 && entry_lock[e+1] && entry_mode[2*(e+1) +: 2] == 2'b01));
            if (refuse) e_rej = 1;
            else begin e_addr_we[e] = 1; e_data = req_data; end
        end
    endtask

    task automatic compare(input string tag);
        bit bad = 0;
        checks++;
        if (out_valid !== e_valid || cfg_we !== e_cfg_we || addr_we !== e_addr_we ||
            rejected !== e_rej) bad = 1;
        for (int j = 0; j < CB; j++) begin
            int e = int'(req_index) + j;
            if (e_cfg_we != 0) begin : chk
                // data compared only for committed parts
            end
        end
        if (|e_addr_we && wr_data !== e_data) bad = 1;
        if (|e_cfg_we) begin
            for (int j = 0; j < CB; j++)
                if (e_data[8*j +: 8] != 8'h00 && wr_data[8*j +: 8] !== e_data[8*j +: 8]) bad = 1;
        end
        if (bad) begin
            errors++;
            $display("FAIL %s: act v=%0b cfg=%h addr=%h data=%h rej=%0b exp v=%0b cfg=%h addr=%h data=%h rej=%0b",
                tag, out_valid, cfg_we, addr_we, wr_data, rejected,
                e_valid, e_cfg_we, e_addr_we, e_data, e_rej);
        end
    endtask

    // Drive a request at the falling edge, check its result one cycle later
    task automatic step(input bit v, input bit cfg, input int idx, input logic [DW-1:0] d,
                        input logic [N-1:0] lk, input logic [2*N-1:0] md,
                        input bit m, input bit b, input string tag);
        req_valid = v; req_is_cfg = cfg; req_index = IW'(idx); req_data = d;
        entry_lock = lk; entry_mode = md; mml = m; rlb = b;
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; req_valid = 0; req_is_cfg = 0; req_index = '0; req_data = '0;
        entry_lock = '0; entry_mode = '0; mml = 0; rlb = 0;
        repeat (3) @(negedge clk);
        e_valid = 0; e_cfg_we = '0; e_addr_we = '0; e_data = '0; e_rej = 0;
        compare("R10 reset");
        rst_n = 1;
        step(0, 0, 0, 0, '0, '0, 0, 0, "R10 idle");
        // R1 / R9: entry 2 locked inside a word of writes
        step(1, 1, 0, 32'h01010101, 8'h04, '0, 0, 0, "R1 R9 locked byte");
        // R2
        step(1, 0, 2, 32'hCAFE0000, 8'h04, '0, 0, 0, "R2 locked addr");
        // R3 bypass
        step(1, 1, 0, 32'h01010101, 8'h04, '0, 0, 1, "R3 bypass cfg");
        step(1, 0, 2, 32'h12345678, 8'h04, '0, 0, 1, "R3 bypass addr");
        step(1, 1, 0, 32'h82868485, '0, '0, 1, 1, "R3 bypass lockdown shapes");
        // R4 / R5 / R6 under lockdown
        step(1, 1, 0, 32'h01018485, '0, '0, 1, 0, "R4 machine-only exec");
        step(1, 1, 4, 32'h01018682, '0, '0, 1, 0, "R5 locked shared code");
        step(1, 1, 0, 32'h01878700, '0, '0, 1, 0, "R6 all-ones shared data");
        step(1, 1, 4, 32'h03868485, '0, '0, 1, 0, "R9 mixed word");
        // R7 reserved shape handling
        step(1, 1, 0, 32'h068E020A, '0, '0, 0, 0, "R7 clear reserved");
        step(1, 1, 0, 32'h0306020A, '0, '0, 1, 0, "R7 lockdown keeps shape");
        // R8 top-of-range neighbour
        step(1, 0, 2, 32'hAAAA5555, 8'h08, 16'h0040, 0, 0, "R8 tor neighbour");
        step(1, 0, 2, 32'hAAAA5555, 8'h08, 16'h00C0, 0, 0, "R8 napot neighbour");
        step(1, 0, 2, 32'hAAAA5555, 8'h08, 16'h0040, 0, 1, "R8 bypass");
        step(1, 0, 7, 32'h00000777, 8'h00, 16'hFFFF, 0, 0, "R8 last entry");
        // R10 out of range bytes and back to back
        step(1, 1, 6, 32'h01010101, 8'h01, '0, 0, 0, "R10 tail bytes");
        step(1, 1, 7, 32'h87878787, 8'h00, '0, 1, 0, "R10 single tail");
        step(0, 1, 0, 32'hFFFFFFFF, 8'h00, '0, 0, 0, "R10 idle after");
        for (int k = 0; k < 400; k++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, N-1),
                 $urandom, N'($urandom), (2*N)'($urandom), $urandom_range(0, 1),
                 $urandom_range(0, 3) == 0, "R9 R10 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule